// File: doc/BRIEF.md
# Scanline Timer with Per-Line Interrupt

This block produces the horizontal timing for a 640x480 raster display from a clock that runs at the pixel rate. A position counter steps through the 800 clocks of each scanline and drives the line sync pulse. At the first pixel of every line it raises an interrupt request, which stays up until the processor acknowledges it.

Vertical timing is not counted in hardware. Interrupt software keeps the line number itself. At the right lines it writes a small control port that holds the frame sync level and the blanking bit. The block also provides a processor cycle enable that pulses once every four pixel clocks. This enable is aligned so that a processor cycle boundary falls exactly on pixel 0 of each line, which means a scanline spans 200 processor cycles.

If a new line begins while the previous request is still unacknowledged, a sticky overrun flag is set. Software clears this flag through the control port.

Top module: `scanline_timer`

## Requirements
- R1: The line period is 800 clocks. Every timing output repeats with that period.
- R2: `hsync_n` is low at line positions 656 through 751 inclusive and high at all other positions. Position p is the number of clocks since reset release, modulo 800.
- R3: `irq` rises at position 0 of every line. The first rise is 800 clocks after reset release.
- R4: Once set, `irq` stays high until a clock edge samples `irq_ack` high. On that edge it clears, unless the same edge begins a new line, in which case it stays set.
- R5: `irq_overrun` is set by a line start while `irq` is high and `irq_ack` is low. It stays set until a write with `wr_data[2]`=1.
- R6: `cpu_en` is high exactly at positions p with p mod 4 = 3. It is therefore high in the last clock before pixel 0.
- R7: A write with `wr_en`=1 loads `blank` from `wr_data[0]` and `vsync` from `wr_data[1]`. The new values show one clock later and are held until the next write.
- R8: While reset is active, the outputs are as follows: `irq`=0, `irq_overrun`=0, `hsync_n`=1, `vsync`=1, `blank`=1 and `cpu_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_ack | input | 1 | Interrupt acknowledge, one clock |
| wr_en | input | 1 | Control port write strobe |
| wr_data | input | 3 | Bit0 blank, bit1 vsync level, bit2 clear overrun |
| irq | output | 1 | Line-start interrupt request |
| irq_overrun | output | 1 | Sticky flag: line start with request pending |
| hsync_n | output | 1 | Active-low line sync |
| vsync | output | 1 | Frame sync level written by software |
| blank | output | 1 | Blanking bit written by software |
| cpu_en | output | 1 | Processor cycle enable, one clock in four |

## Verification
The embedded assertions check several properties on every cycle. These are the counter range, the position at which sync begins, the setting of the request at each line end, its persistence while unacknowledged, the persistence of the overrun flag, the alignment of the cycle enable with line end, and the loading of the control bits. Other behaviour needs stimulus from the bench's scenarios. This includes the exact clock of the first request after reset, the clearing effect of an acknowledge, and the rule that a line start wins over a simultaneous acknowledge without raising an overrun. It also includes setting and clearing the overrun flag across two lines, and the absolute sync edges on a second line.

// File: rtl/scanline_timer.sv
module scanline_timer #(
  parameter int H_VISIBLE = 640,
  parameter int H_FRONT   = 16,
  parameter int H_SYNC    = 96,
  parameter int H_BACK    = 48,
  parameter int CYC_DIV   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       irq_ack,
  input  logic       wr_en,
  input  logic [2:0] wr_data,
  output logic       irq,
  output logic       irq_overrun,
  output logic       hsync_n,
  output logic       vsync,
  output logic       blank,
  output logic       cpu_en
);

  localparam int H_TOTAL  = H_VISIBLE + H_FRONT + H_SYNC + H_BACK;
  localparam int HW       = $clog2(H_TOTAL);
  localparam int PW       = (CYC_DIV > 1) ? $clog2(CYC_DIV) : 1;
  localparam logic [HW-1:0] LAST     = HW'(H_TOTAL - 1);
  localparam logic [HW-1:0] SYNC_BEG = HW'(H_VISIBLE + H_FRONT);
  localparam logic [HW-1:0] SYNC_END = HW'(H_VISIBLE + H_FRONT + H_SYNC);
  localparam logic [PW-1:0] PH_LAST  = PW'(CYC_DIV - 1);

  logic [HW-1:0] hcount, hnext;
  logic [PW-1:0] phase;
  logic          line_end;

  assign line_end = (hcount == LAST);
  assign hnext    = line_end ? '0 : hcount + 1'b1;
  assign cpu_en   = (phase == PH_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcount  <= '0;
      hsync_n <= 1'b1;
    end else begin
      hcount  <= hnext;
      hsync_n <= !((hnext >= SYNC_BEG) && (hnext < SYNC_END));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || line_end || cpu_en) phase <= '0;
    else                              phase <= phase + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq         <= 1'b0;
      irq_overrun <= 1'b0;
    end else begin
      if (line_end)     irq <= 1'b1;
      else if (irq_ack) irq <= 1'b0;
      if (line_end && irq && !irq_ack) irq_overrun <= 1'b1;
      else if (wr_en && wr_data[2])    irq_overrun <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blank <= 1'b1;
      vsync <= 1'b1;
    end else if (wr_en) begin
      blank <= wr_data[0];
      vsync <= wr_data[1];
    end
  end

  AST_HCOUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    hcount <= LAST);  // R1
  AST_HSYNC_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hsync_n) |-> hcount == SYNC_BEG);  // R2
  AST_IRQ_AT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> irq);  // R3
  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_ack |=> irq);  // R4
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_overrun && !(wr_en && wr_data[2]) |=> irq_overrun);  // R5
  AST_CPU_EN_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |-> cpu_en);  // R6
  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> blank == $past(wr_data[0]) && vsync == $past(wr_data[1]));  // R7

endmodule

// File: tb/scanline_timer_tb.sv
module scanline_timer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_ack = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_data = 3'b000;
  logic irq, irq_overrun, hsync_n, vsync, blank, cpu_en;

  scanline_timer u_dut (
    .clk(clk), .rst_n(rst_n), .irq_ack(irq_ack), .wr_en(wr_en), .wr_data(wr_data),
    .irq(irq), .irq_overrun(irq_overrun), .hsync_n(hsync_n), .vsync(vsync),
    .blank(blank), .cpu_en(cpu_en)
  );

  always #4 clk = ~clk;

  typedef struct {
    int    cyc;
    int    sig;
    logic  val;
    string req;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  function automatic logic get_sig(int s);
    case (s)
      0: return irq;
      1: return irq_overrun;
      2: return hsync_n;
      3: return vsync;
      4: return blank;
      default: return cpu_en;
    endcase
  endfunction

  task automatic chk(string req, int s, logic act, logic exp, int c);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s sig%0d cycle %0d actual=%0b expected=%0b", req, s, c, act, exp);
    end
  endtask

  task automatic expect_at(int c, int s, logic v, string req);
    exp_t e;
    e.cyc = c; e.sig = s; e.val = v; e.req = req;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = q.size() - 1; i >= 0; i--) begin
        if (q[i].cyc == cyc) begin
          chk(q[i].req, q[i].sig, get_sig(q[i].sig), q[i].val, cyc);
          q.delete(i);
        end
      end
    end
  end

  task automatic wait_cyc(int n);
    while (cyc != n) @(negedge clk);
  endtask

  task automatic do_write(int n, logic [2:0] d);
    wait_cyc(n);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_ack(int n);
    wait_cyc(n);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  initial begin
    // R8 reset state, sampled while reset is held
    repeat (3) @(negedge clk);
    chk("R8", 0, irq, 1'b0, 0);
    chk("R8", 1, irq_overrun, 1'b0, 0);
    chk("R8", 2, hsync_n, 1'b1, 0);
    chk("R8", 3, vsync, 1'b1, 0);
    chk("R8", 4, blank, 1'b1, 0);
    chk("R8", 5, cpu_en, 1'b0, 0);

    // R2 sync window on first line, R1 on the second
    expect_at(655, 2, 1'b1, "R2");
    expect_at(656, 2, 1'b0, "R2");
    expect_at(751, 2, 1'b0, "R2");
    expect_at(752, 2, 1'b1, "R2");
    expect_at(1455, 2, 1'b1, "R1");
    expect_at(1456, 2, 1'b0, "R1");
    // R6 cycle enable phase
    for (int c = 1; c < 8; c++) expect_at(c, 5, (c % 4 == 3), "R6");
    expect_at(799, 5, 1'b1, "R6");
    expect_at(800, 5, 1'b0, "R6");
    expect_at(803, 5, 1'b1, "R6");
    // R7 control writes
    expect_at(10, 4, 1'b1, "R7");
    expect_at(11, 4, 1'b0, "R7");
    expect_at(11, 3, 1'b0, "R7");
    expect_at(21, 3, 1'b1, "R7");
    expect_at(21, 4, 1'b0, "R7");
    expect_at(500, 3, 1'b1, "R7");
    // R3 first request
    expect_at(799, 0, 1'b0, "R3");
    expect_at(800, 0, 1'b1, "R3");
    // R4 held then cleared
    expect_at(805, 0, 1'b1, "R4");
    expect_at(806, 0, 1'b0, "R4");
    expect_at(1600, 0, 1'b1, "R3");
    // R5 overrun at next line while pending
    expect_at(2399, 1, 1'b0, "R5");
    expect_at(2400, 1, 1'b1, "R5");
    expect_at(2500, 1, 1'b1, "R5");
    expect_at(2501, 1, 1'b0, "R5");
    // R4 line start beats simultaneous ack; no overrun
    expect_at(3200, 0, 1'b1, "R4");
    expect_at(3200, 1, 1'b0, "R5");
    expect_at(3211, 0, 1'b0, "R4");

    @(negedge clk);
    #1 rst_n = 1'b1;

    do_write(10, 3'b000);
    do_write(20, 3'b010);
    do_ack(805);
    do_write(2500, 3'b110);
    do_ack(3199);
    do_ack(3210);
    wait_cyc(3300);
    if (q.size() != 0) begin
      fails += q.size();
      total += q.size();
      $display("FAIL unchecked expectations remain: actual=%0d expected=0", q.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule